// File: doc/BRIEF.md
# Chained Depth-Expansion FIFO

This block builds one deep first-in/first-out queue out of several identical storage slices joined in a ring. Each slice holds its own storage array, its own read and write pointers and its own occupancy count. At any moment exactly one slice owns the right to accept writes and exactly one owns the right to supply reads. When the write owner stores a word into its last physical location, it hands write ownership to the next slice in the ring with a single-cycle pulse on the write field of its outgoing link. Read ownership is handed on in the same way when the read owner consumes its last physical location. The last slice's link feeds back into the first slice, which closes the ring.

The top level broadcasts the write strobe, write data, read strobe and reset to every slice. Each slice acts on a strobe only while it holds the matching token. The outgoing link of each slice carries separate write and read hand-off fields, so the next slice can tell which token it is receiving. Slice 0 is strapped as the first-load slice, so after reset it holds both tokens. The per-slice empty flags and full flags are merged into composite flags, and the read words are merged into one output. The head word is available combinationally whenever the queue is not empty. When the chain has a single slice, its expansion input is grounded and it runs on its own without tokens.

Top module: `chain_fifo`

## Requirements
- R1: While reset is held and on release, `empty` is 1 and `full` is 0, and slice 0 owns both tokens. The first word written after reset is the first word read.
- R2: Words leave in the order they were accepted, across the whole capacity of SLICES*SLICE_DEPTH words and across any number of wraps of the ring.
- R3: `full` is 1 exactly when SLICES*SLICE_DEPTH words are stored. A write requested while `full` is 1 stores nothing.
- R4: `empty` is 1 exactly when no word is stored. A read requested while `empty` is 1 removes nothing and moves no pointer.
- R5: A slice that writes its last physical location drives a one-cycle pulse on the write field of its outgoing link. From the next cycle, the following slice in the ring owns writes and the sender does not.
- R6: A slice that reads its last physical location drives a one-cycle pulse on the read field of its outgoing link. From the next cycle, the following slice owns reads and the sender does not.
- R7: The composite `empty` is 1 only when every slice is empty. The composite `full` is 1 only when every slice is full. Filling one slice alone does not raise `full`.
- R8: A read and a write requested in the same cycle both take effect, each judged against the flags before the clock edge. At full only the read is performed, and at empty only the write is performed.
- R9: `rd_data` shows the oldest stored word whenever `empty` is 0. Only the slice holding the read token contributes to it, and every other slice presents zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request, consumes the head word |
| rd_data | output | WIDTH | Head word, valid while `empty` is 0 |
| empty | output | 1 | Composite empty flag |
| full | output | 1 | Composite full flag |

## Verification
On every cycle, the assertions check the following:
- exactly one slice owns each token;
- no slice writes into a full array or reads from an empty one;
- every link pulse moves ownership from sender to receiver on the next edge.

Only the bench scenarios can show the ordering across slice boundaries, the exact capacity at which `full` rises, and that requests refused at the flags leave the stored contents untouched. Those scenarios are a full fill, overfill, drain and underflow, a sweep over every occupancy with all request combinations, and a long pseudo-random run.

// File: rtl/chain_fifo_pkg.sv
package chain_fifo_pkg;

    // Token hand-off carried on each link between neighbouring slices.
    typedef struct packed {
        logic wr_pass;
        logic rd_pass;
    } link_t;

endpackage

// File: rtl/chain_slice.sv
module chain_slice
    import chain_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             first_ld,
    input  logic             solo,
    input  link_t            xi,
    output link_t            xo,
    input  logic             wr_go,
    input  logic             rd_go,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_word,
    output logic             is_empty,
    output logic             is_full,
    output logic             own_wr,
    output logic             own_rd
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          wtok;
        logic          rtok;
    } slice_st_t;

    slice_st_t s_d, s_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic wr_mine, rd_mine, wr_last, rd_last;

    always_comb begin
        s_d     = s_q;
        wr_mine = wr_go && (solo || s_q.wtok);
        rd_mine = rd_go && (solo || s_q.rtok);
        wr_last = wr_mine && (s_q.wp == LAST);
        rd_last = rd_mine && (s_q.rp == LAST);

        if (wr_mine) s_d.wp = wr_last ? '0 : s_q.wp + 1'b1;
        if (rd_mine) s_d.rp = rd_last ? '0 : s_q.rp + 1'b1;

        unique case ({wr_mine, rd_mine})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase

        s_d.wtok = (s_q.wtok && !(wr_last && !solo)) || xi.wr_pass;
        s_d.rtok = (s_q.rtok && !(rd_last && !solo)) || xi.rd_pass;

        xo.wr_pass = !solo && wr_last;
        xo.rd_pass = !solo && rd_last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.wtok <= first_ld;
            s_q.rtok <= first_ld;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_mine) mem_q[s_q.wp] <= wr_data;
    end

    assign own_wr   = solo || s_q.wtok;
    assign own_rd   = solo || s_q.rtok;
    assign rd_word  = own_rd ? mem_q[s_q.rp] : '0;
    assign is_empty = (s_q.cnt == '0);
    assign is_full  = (s_q.cnt == CW'(DEPTH));

    // R3: a slice never stores into a full array
    a_r3_no_write_into_full: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mine |-> (s_q.cnt != CW'(DEPTH)));

    // R4: a slice never consumes from an empty array
    a_r4_no_read_from_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mine |-> (s_q.cnt != '0));

    // R5: write ownership leaves the sender and arrives at the receiver
    a_r5_wr_token_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        xo.wr_pass |=> !s_q.wtok);
    a_r5_wr_token_arrives: assert property (@(posedge clk) disable iff (!rst_n)
        xi.wr_pass |=> s_q.wtok);

    // R6: read ownership leaves the sender and arrives at the receiver
    a_r6_rd_token_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        xo.rd_pass |=> !s_q.rtok);
    a_r6_rd_token_arrives: assert property (@(posedge clk) disable iff (!rst_n)
        xi.rd_pass |=> s_q.rtok);

endmodule

// File: rtl/chain_merge.sv
module chain_merge #(
    parameter int SLICES = 4,
    parameter int WIDTH  = 9
) (
    input  logic [SLICES-1:0]            slice_empty,
    input  logic [SLICES-1:0]            slice_full,
    input  logic [SLICES-1:0][WIDTH-1:0] slice_word,
    output logic                         all_empty,
    output logic                         all_full,
    output logic [WIDTH-1:0]             head_word
);

    always_comb begin
        all_empty = &slice_empty;
        all_full  = &slice_full;
        head_word = '0;
        for (int i = 0; i < SLICES; i++) begin
            head_word = head_word | slice_word[i];
        end
    end

endmodule

// File: rtl/chain_fifo.sv
module chain_fifo
    import chain_fifo_pkg::*;
#(
    parameter int SLICES      = 4,
    parameter int SLICE_DEPTH = 8,
    parameter int WIDTH       = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);

    localparam logic SOLO = (SLICES == 1);

    link_t                        lnk [SLICES];
    logic  [SLICES-1:0]           s_empty, s_full, s_own_wr, s_own_rd;
    logic  [SLICES-1:0][WIDTH-1:0] s_word;
    logic                         wr_go, rd_go;

    assign wr_go = wr_en && !full;
    assign rd_go = rd_en && !empty;

    for (genvar i = 0; i < SLICES; i++) begin : g_slice
        localparam int PREV = (i == 0) ? SLICES - 1 : i - 1;
        link_t xi_w;

        if (SOLO) begin : g_solo
            assign xi_w = '0;
        end else begin : g_ring
            assign xi_w = lnk[PREV];
        end

        chain_slice #(
            .DEPTH (SLICE_DEPTH),
            .WIDTH (WIDTH)
        ) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .first_ld (i == 0),
            .solo     (SOLO),
            .xi       (xi_w),
            .xo       (lnk[i]),
            .wr_go    (wr_go),
            .rd_go    (rd_go),
            .wr_data  (wr_data),
            .rd_word  (s_word[i]),
            .is_empty (s_empty[i]),
            .is_full  (s_full[i]),
            .own_wr   (s_own_wr[i]),
            .own_rd   (s_own_rd[i])
        );
    end

    chain_merge #(
        .SLICES (SLICES),
        .WIDTH  (WIDTH)
    ) u_merge (
        .slice_empty (s_empty),
        .slice_full  (s_full),
        .slice_word  (s_word),
        .all_empty   (empty),
        .all_full    (full),
        .head_word   (rd_data)
    );

    // R5: exactly one slice owns writes at any time
    a_r5_one_write_owner: assert property (@(posedge clk) disable iff (!rst_n)
        SOLO || ($countones(s_own_wr) == 1));

    // R9: exactly one slice owns reads and therefore drives rd_data
    a_r9_one_read_owner: assert property (@(posedge clk) disable iff (!rst_n)
        SOLO || ($countones(s_own_rd) == 1));

    // R7: composite full and composite empty never coexist
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

endmodule

// File: tb/sim_chain_fifo.sv
module sim_chain_fifo;

    localparam int N   = 3;
    localparam int D   = 4;
    localparam int W   = 9;
    localparam int CAP = N * D;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         empty, full;

    int vectors = 0;
    int misses  = 0;
    logic [W-1:0] mq [$];

    always #10 clk = ~clk;

    chain_fifo #(.SLICES(N), .SLICE_DEPTH(D), .WIDTH(W)) u0 (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
        .rd_en (rd_en), .rd_data (rd_data), .empty (empty), .full (full)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare outputs against the model, apply one request pair, advance one edge.
    task automatic step(input logic w, input logic r, input logic [W-1:0] d);
        bit e_exp, f_exp, acc_w, acc_r;
        e_exp = (mq.size() == 0);
        f_exp = (mq.size() == CAP);
        chk(empty == e_exp, "R4 R7 empty flag", int'(empty), int'(e_exp));
        chk(full == f_exp, "R3 R7 full flag", int'(full), int'(f_exp));
        if (!e_exp) chk(rd_data == mq[0], "R2 R9 head word", int'(rd_data), int'(mq[0]));
        wr_en = w; rd_en = r; wr_data = d;
        acc_w = w && !f_exp;   // R8: each side judged on pre-edge flags
        acc_r = r && !e_exp;
        @(posedge clk);
        #1;
        if (acc_r) void'(mq.pop_front());
        if (acc_w) mq.push_back(d);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin : main
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        // R1: flags during reset
        chk(empty == 1'b1, "R1 empty in reset", int'(empty), 1);
        chk(full == 1'b0, "R1 full in reset", int'(full), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(empty == 1'b1, "R1 empty after reset", int'(empty), 1);
        chk(full == 1'b0, "R1 full after reset", int'(full), 0);

        // R3 R5 R7: fill every slice; full must rise only on the last word
        for (int k = 0; k < CAP; k++) step(1'b1, 1'b0, W'(k + 16));
        // R3: writes while full are ignored
        step(1'b1, 1'b0, 9'h1FF);
        step(1'b1, 1'b0, 9'h1FE);
        // R2 R6: drain across all slice boundaries in order
        for (int k = 0; k < CAP; k++) step(1'b0, 1'b1, '0);
        // R4: reads while empty are ignored
        step(1'b0, 1'b1, '0);
        step(1'b0, 1'b1, '0);
        step(1'b1, 1'b0, 9'h055);
        chk(rd_data == 9'h055, "R4 head after ignored reads", int'(rd_data), 'h55);
        step(1'b0, 1'b1, '0);

        // R8: simultaneous requests at full and at empty
        for (int k = 0; k < CAP; k++) step(1'b1, 1'b0, W'(k + 64));
        step(1'b1, 1'b1, 9'h0AA);
        step(1'b1, 1'b1, 9'h0AB);
        for (int k = 0; k < CAP; k++) step(1'b0, 1'b1, '0);
        step(1'b1, 1'b1, 9'h0CC);
        step(1'b0, 1'b1, '0);

        // Sweep: every occupancy, every request pair, several ring offsets
        for (int occ = 0; occ <= CAP; occ++) begin
            for (int k = 0; k < occ; k++) step(1'b1, 1'b0, W'(occ * 13 + k));
            for (int c = 0; c < 8; c++) step(c[0], c[1], W'(occ * 7 + c + 200));
            while (mq.size() > 0) step(1'b0, 1'b1, '0);
            step(1'b0, 1'b0, '0);
        end

        // Long pseudo-random run, biased to reach both flags
        lf = 16'hACE1;
        for (int t = 0; t < 3000; t++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (t[9]) step(lf[0] | lf[1], lf[2] & lf[3], W'(lf[12:4]));
            else      step(lf[0] & lf[1], lf[2] | lf[3], W'(lf[12:4]));
        end
        while (mq.size() > 0) step(1'b0, 1'b1, '0);
        step(1'b0, 1'b0, '0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule